// File: doc/BRIEF.md
# NAND Flash Command Sequencer

The block runs one NAND flash operation each time software writes a control word with the start bit set. An operation has up to four phases, always in this order. First comes one command cycle, then any address cycles picked by a mask, then an optional pause until the device's ready/busy line has gone low and come back high, and last an optional read phase. Software programs the address bytes and two destination base addresses through a small word-indexed register port, then polls a busy bit or waits for the interrupt.

On the flash side the block drives the command-latch and address-latch enables, the write and read strobes and an 8-bit output bus with its own output enable. It samples the 8-bit input bus and the ready/busy line, which goes through a synchronizer first. Each byte read in the data phase leaves as a one-cycle stream item that carries a destination address. The first 2048 bytes land at sequential addresses from the main base. The bytes after them, normally the spare area, land at sequential addresses from the spare base.

The controller states are IDLE, CMD, ADDR, WAIT_LO, WAIT_HI, READ and DONE. The transitions are:
- start: IDLE to CMD.
- cmd_to_addr: CMD to ADDR, taken when the mask is not empty.
- addr_loop: ADDR to ADDR, taken while mask bits remain.
- post_addr: from CMD or ADDR to WAIT_LO when the wait flag is set. Otherwise it goes to READ when there is data, and otherwise to DONE.
- rb_fell: WAIT_LO to WAIT_HI.
- rb_rose: WAIT_HI to READ or to DONE.
- last_byte: READ to DONE.
- retire: DONE to IDLE.

Top module: `nand_seq`

## Requirements
- R1: A write to register word 0 with bit 31 set starts an operation when the block is idle. Reading word 0 returns busy in bit 31, the latched interrupt enable in bit 30, the done flag in bit 0 and zero in every other bit. Busy reads 1 from the cycle after the start until the operation retires.
- R2: Every operation begins with exactly one write-strobe cycle. During that cycle the command-latch enable is high, the address-latch enable is low and the output bus carries control bits 23:16.
- R3: Control bits 28:24 form an address mask. Value 0x10 selects byte A, 0x08 selects byte B, 0x04 selects byte D, 0x02 selects byte E and 0x01 selects byte F. Selected bytes go out in the order A, B, D, E, F, one write-strobe cycle each, with the address-latch enable high and the command-latch enable low.
- R4: Register word 1 holds A in bits 15:8 and B in bits 7:0, and reads back with bits 31:16 zero. Word 2 holds C in bits 31:24 (stored and read back, never sent), D in 23:16, E in 15:8 and F in 7:0. Word 3 is the main base and word 4 is the spare base.
- R5: With control bit 15 set, the block waits after the address phase until ready/busy is seen low, then until it is seen high again. It stays busy and issues no strobe and no stream item during that wait.
- R6: With control bit 13 set and bits 11:0 nonzero, the block issues that many read-strobe pulses. It captures the input bus at the end of each low phase and emits one stream item per byte. The output enable stays low during the read phase. If bit 13 is clear or the length is zero, no read strobe and no stream item occur.
- R7: Byte n of the read phase goes to main base + n when n < 2048, and to spare base + (n - 2048) otherwise.
- R8: The done flag is set when an operation retires and is cleared by the next accepted start. The interrupt output equals the done flag ANDed with control bit 30 of the operation that set it.
- R9: A control write that arrives while the block is busy has no effect. It changes no latched field and adds no bus cycle.
- R10: Every write and read strobe is low for PULSE_CYC clock cycles and then high for PULSE_CYC cycles.
- R11: After reset the status word and the interrupt output are 0, both strobes are high, both latch enables and the output enable are low, and no stream item is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index (0 control/status, 1 to 2 address, 3 main base, 4 spare base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| irq | output | 1 | Completion interrupt |
| nf_cle | output | 1 | Command-latch enable |
| nf_ale | output | 1 | Address-latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Flash bus output value |
| nf_io_oe | output | 1 | Flash bus output enable |
| nf_io_in | input | 8 | Flash bus input value |
| nf_rb_n | input | 1 | Ready (high) / busy (low) from the device |
| rd_valid | output | 1 | Stream item valid |
| rd_addr | output | 32 | Stream item destination address |
| rd_data | output | 8 | Stream item byte |

## Verification
The hardest situation to reach from the ports is a control write that lands while the block sits in the ready/busy wait. The write must leave no trace, and no read byte may escape before the line comes back high. The bench issues a page-read second cycle with the wait flag and a 0x840-byte length, and holds ready/busy high until all command strobes have been seen. It then writes a conflicting control word with the interrupt enabled. After that it holds ready/busy low for a long window while it polls busy and counts stream items. Finally it releases the line and lets the scoreboard follow the read across the 2048-byte split into the spare region.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int REG_W       = 32;
    localparam int REG_IDX_W   = 3;
    localparam int CTRL_LEN_W  = 12;
    localparam int N_ADDR_SEND = 5;

    localparam logic [REG_IDX_W-1:0] RIX_CTRL  = 3'd0;
    localparam logic [REG_IDX_W-1:0] RIX_ADRLO = 3'd1;
    localparam logic [REG_IDX_W-1:0] RIX_ADRHI = 3'd2;
    localparam logic [REG_IDX_W-1:0] RIX_MAIN  = 3'd3;
    localparam logic [REG_IDX_W-1:0] RIX_SPARE = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_READ,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic                  irq_en;
        logic [7:0]            opcode;
        logic                  wait_rb;
        logic                  data_en;
        logic [CTRL_LEN_W-1:0] len;
    } op_t;

    function automatic op_t decode_ctrl(input logic [REG_W-1:0] w);
        op_t o;
        o.irq_en  = w[30];
        o.opcode  = w[23:16];
        o.wait_rb = w[15];
        o.data_en = w[13];
        o.len     = w[CTRL_LEN_W-1:0];
        return o;
    endfunction

    function automatic logic [N_ADDR_SEND-1:0] ctrl_mask(input logic [REG_W-1:0] w);
        return w[28:24];
    endfunction

    // Lowest send slot (0 = first on the bus) whose mask bit is still pending;
    // slot i is tracked by mask bit N_ADDR_SEND-1-i.
    function automatic logic [2:0] first_pending(input logic [N_ADDR_SEND-1:0] p);
        logic [2:0] r;
        r = 3'd0;
        for (int i = N_ADDR_SEND - 1; i >= 0; i--) begin
            if (p[N_ADDR_SEND-1-i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [REG_W-1:0]     wdata,
    output logic [15:0]          adr_lo,
    output logic [REG_W-1:0]     adr_hi,
    output logic [REG_W-1:0]     main_base,
    output logic [REG_W-1:0]     spare_base
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_lo     <= '0;
            adr_hi     <= '0;
            main_base  <= '0;
            spare_base <= '0;
        end else if (we) begin
            unique case (idx)
                RIX_ADRLO: adr_lo     <= wdata[15:0];
                RIX_ADRHI: adr_hi     <= wdata;
                RIX_MAIN:  main_base  <= wdata;
                RIX_SPARE: spare_base <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic low,
    output logic sample,
    output logic last
);

    localparam int PERIOD = 2 * PULSE_CYC;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!go)   cnt_q <= '0;
        else if (last)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        low    = go && (cnt_q < CW'(PULSE_CYC));
        sample = go && (cnt_q == CW'(PULSE_CYC - 1));
        last   = go && (cnt_q == CW'(PERIOD - 1));
    end

endmodule

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
            assign q = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/nand_seq_dest.sv
module nand_seq_dest
    import nand_seq_pkg::*;
#(
    parameter int MAIN_BYTES = 2048
) (
    input  logic [CTRL_LEN_W-1:0] idx,
    input  logic [REG_W-1:0]      main_base,
    input  logic [REG_W-1:0]      spare_base,
    output logic [REG_W-1:0]      addr
);

    localparam logic [REG_W-1:0] SPLIT = REG_W'(MAIN_BYTES);

    logic [REG_W-1:0] n;

    always_comb begin
        n = REG_W'(idx);
        if (n < SPLIT) addr = main_base + n;
        else           addr = spare_base + (n - SPLIT);
    end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int PULSE_CYC  = 2,
    parameter int MAIN_BYTES = 2048,
    parameter int RB_SYNC    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq,
    output logic                 nf_cle,
    output logic                 nf_ale,
    output logic                 nf_we_n,
    output logic                 nf_re_n,
    output logic [7:0]           nf_io_out,
    output logic                 nf_io_oe,
    input  logic [7:0]           nf_io_in,
    input  logic                 nf_rb_n,
    output logic                 rd_valid,
    output logic [REG_W-1:0]     rd_addr,
    output logic [7:0]           rd_data
);

    localparam int LEN_W = CTRL_LEN_W;

    seq_state_e            state_q, state_d;
    op_t                   op_q;
    logic [N_ADDR_SEND-1:0] pending_q;
    logic [LEN_W-1:0]      byte_cnt_q;
    logic                  done_q;
    logic                  rd_valid_q;
    logic [7:0]            rd_data_q;
    logic [REG_W-1:0]      rd_addr_q;

    logic [15:0]      adr_lo;
    logic [REG_W-1:0] adr_hi, main_base, spare_base, dest_addr;
    logic             rb_s;
    logic             stb_go, stb_low, stb_sample, stb_last;
    logic             start, busy, has_data, ctrl_wr;
    logic [2:0]       cur_slot;
    logic [N_ADDR_SEND-1:0] cur_bit;
    logic [7:0]       cur_byte;
    seq_state_e       after_addr;

    nand_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .adr_lo     (adr_lo),
        .adr_hi     (adr_hi),
        .main_base  (main_base),
        .spare_base (spare_base)
    );

    nand_seq_sync #(.STAGES(RB_SYNC)) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nf_rb_n),
        .q     (rb_s)
    );

    nand_seq_strobe #(.PULSE_CYC(PULSE_CYC)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (stb_go),
        .low    (stb_low),
        .sample (stb_sample),
        .last   (stb_last)
    );

    nand_seq_dest #(.MAIN_BYTES(MAIN_BYTES)) u_dest (
        .idx        (byte_cnt_q),
        .main_base  (main_base),
        .spare_base (spare_base),
        .addr       (dest_addr)
    );

    // ---------------- decode helpers ----------------
    always_comb begin
        busy     = (state_q != ST_IDLE);
        ctrl_wr  = reg_we && (reg_idx == RIX_CTRL);
        start    = ctrl_wr && reg_wdata[31] && !busy;
        has_data = op_q.data_en && (op_q.len != '0);
        cur_slot = first_pending(pending_q);
        cur_bit  = N_ADDR_SEND'(1) << (N_ADDR_SEND - 1 - int'(cur_slot));
        stb_go   = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_READ);

        unique case (cur_slot)
            3'd0:    cur_byte = adr_lo[15:8];
            3'd1:    cur_byte = adr_lo[7:0];
            3'd2:    cur_byte = adr_hi[23:16];
            3'd3:    cur_byte = adr_hi[15:8];
            default: cur_byte = adr_hi[7:0];
        endcase

        if (op_q.wait_rb)  after_addr = ST_WAIT_LO;
        else if (has_data) after_addr = ST_READ;
        else               after_addr = ST_DONE;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CMD;
            ST_CMD:     if (stb_last) state_d = (pending_q != '0) ? ST_ADDR : after_addr;
            ST_ADDR:    if (stb_last && ((pending_q & ~cur_bit) == '0)) state_d = after_addr;
            ST_WAIT_LO: if (!rb_s) state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (rb_s) state_d = has_data ? ST_READ : ST_DONE;
            ST_READ:    if (stb_last && (byte_cnt_q == op_q.len - 1'b1)) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= '0;
            pending_q  <= '0;
            byte_cnt_q <= '0;
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            rd_addr_q  <= '0;
        end else begin
            if (start) begin
                op_q       <= decode_ctrl(reg_wdata);
                pending_q  <= ctrl_mask(reg_wdata);
                byte_cnt_q <= '0;
                done_q     <= 1'b0;
            end
            if (state_q == ST_ADDR && stb_last) pending_q <= pending_q & ~cur_bit;
            if (state_q == ST_READ && stb_last) byte_cnt_q <= byte_cnt_q + 1'b1;
            if (state_q == ST_DONE) done_q <= 1'b1;
            rd_valid_q <= (state_q == ST_READ) && stb_sample;
            if ((state_q == ST_READ) && stb_sample) begin
                rd_data_q <= nf_io_in;
                rd_addr_q <= dest_addr;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        nf_cle    = (state_q == ST_CMD);
        nf_ale    = (state_q == ST_ADDR);
        nf_io_oe  = nf_cle || nf_ale;
        nf_we_n   = !(nf_io_oe && stb_low);
        nf_re_n   = !((state_q == ST_READ) && stb_low);
        nf_io_out = nf_cle ? op_q.opcode : (nf_ale ? cur_byte : 8'h00);
        irq       = done_q && op_q.irq_en;
        rd_valid  = rd_valid_q;
        rd_data   = rd_data_q;
        rd_addr   = rd_addr_q;

        unique case (reg_idx)
            RIX_CTRL:  reg_rdata = {busy, op_q.irq_en, 29'd0, done_q};
            RIX_ADRLO: reg_rdata = {16'd0, adr_lo};
            RIX_ADRHI: reg_rdata = adr_hi;
            RIX_MAIN:  reg_rdata = main_base;
            RIX_SPARE: reg_rdata = spare_base;
            default:   reg_rdata = '0;
        endcase
    end

    // ---------------- assertions ----------------
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_CMD)); // R1

    AST_BUSY_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable(op_q)); // R9

    AST_ADDR_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && stb_last) |=> ($countones(pending_q) + 1 == $countones($past(pending_q)))); // R3

    AST_WAIT_HOLDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LO && rb_s) |=> (state_q == ST_WAIT_LO)); // R5

    AST_WAIT_HOLDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI && !rb_s) |=> (state_q == ST_WAIT_HI)); // R5

    AST_STREAM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(state_q) == ST_READ)); // R6

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe); // R6

    AST_DONE_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_DONE && state_q == ST_IDLE)); // R8

    AST_WE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nf_we_n) && (PULSE_CYC > 1)) |=> !nf_we_n); // R10

endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb_top;

    localparam int PULSE = 2;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic [7:0] io;
    } lat_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  data;
    } str_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out, nf_io_in;
    logic        nf_rb_n = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic [7:0]  rd_data;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   fidx = 0;
    int   n_stream = 0;
    int   n_latch = 0;
    bit   finished = 1'b0;
    lat_t exp_lat[$];
    str_t exp_str[$];

    always #2.5 clk = ~clk;

    assign nf_io_in = 8'(fidx) ^ 8'h5A;

    nand_seq #(.PULSE_CYC(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
        .nf_rb_n(nf_rb_n), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(3'd0, s);
            if (!s[31]) return;
        end
    endtask

    task automatic push_lat(input logic cle, input logic [7:0] v);
        lat_t l;
        l.cle = cle; l.ale = !cle; l.io = v;
        exp_lat.push_back(l);
    endtask

    task automatic push_read(input int len, input logic [31:0] mb, input logic [31:0] sb);
        str_t s;
        for (int i = 0; i < len; i++) begin
            s.addr = (i < 2048) ? mb + 32'(i) : sb + 32'(i - 2048);
            s.data = 8'(fidx + i) ^ 8'h5A;
            exp_str.push_back(s);
        end
    endtask

    // Monitor: bus cycles, strobe widths, flash read model, stream scoreboard
    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_low = 0, re_low = 0;
    bit   oe_in_read = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nf_we_n) we_low++;
            if (!nf_re_n) begin
                re_low++;
                if (nf_io_oe) oe_in_read = 1'b1;
            end
            if (nf_we_n && !prev_we) begin
                lat_t got, e;
                got.cle = nf_cle; got.ale = nf_ale; got.io = nf_io_out;
                n_latch++;
                chk(we_low == PULSE, "R10 write strobe low width", 32'(we_low), 32'(PULSE));
                if (exp_lat.size() == 0)
                    chk(1'b0, "R2/R3 unexpected bus cycle", 32'(got), 32'hFFFF_FFFF);
                else begin
                    e = exp_lat.pop_front();
                    chk(got == e, e.cle ? "R2 command cycle" : "R3 address cycle", 32'(got), 32'(e));
                end
                we_low = 0;
            end
            if (nf_re_n && !prev_re) begin
                chk(re_low == PULSE, "R10 read strobe low width", 32'(re_low), 32'(PULSE));
                chk(!oe_in_read, "R6 bus driven during read", 32'(oe_in_read), 32'd0);
                re_low = 0; oe_in_read = 1'b0;
                fidx++;
            end
            if (rd_valid) begin
                str_t e;
                n_stream++;
                if (exp_str.size() == 0)
                    chk(1'b0, "R6 unexpected stream item", rd_addr, 32'hFFFF_FFFF);
                else begin
                    e = exp_str.pop_front();
                    chk(rd_addr == e.addr, "R7 stream address", rd_addr, e.addr);
                    chk(rd_data == e.data, "R6 stream data", 32'(rd_data), 32'(e.data));
                end
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog act=timeout exp=idle");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int          snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        reg_read(3'd0, s);
        chk(s == 32'd0, "R11 status after reset", s, 32'd0);
        chk({irq, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, rd_valid} == 7'b0110000,
            "R11 pins after reset", 32'({irq, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, rd_valid}), 32'h30);

        // R4 address registers
        reg_write(3'd1, 32'hFFFF_A1B2);
        reg_write(3'd2, 32'hC3D4_E5F6);
        reg_write(3'd3, 32'h0001_0000);
        reg_write(3'd4, 32'h0008_0000);
        reg_read(3'd1, s);
        chk(s == 32'h0000_A1B2, "R4 word 1 readback", s, 32'h0000_A1B2);
        reg_read(3'd2, s);
        chk(s == 32'hC3D4_E5F6, "R4 word 2 readback", s, 32'hC3D4_E5F6);

        // Device reset opcode, no address, interrupt enabled
        push_lat(1'b1, 8'hFF);
        reg_write(3'd0, 32'hC0FF_0000);
        reg_read(3'd0, s);
        chk(s[31] == 1'b1, "R1 busy after start", s, 32'h8000_0000);
        wait_idle();
        reg_read(3'd0, s);
        chk(s == 32'h4000_0001, "R8 status after irq op", s, 32'h4000_0001);
        chk(irq == 1'b1, "R8 irq with enable", 32'(irq), 32'd1);

        // Page-read first cycle: all five address slots
        push_lat(1'b1, 8'h00);
        push_lat(1'b0, 8'hA1); push_lat(1'b0, 8'hB2);
        push_lat(1'b0, 8'hD4); push_lat(1'b0, 8'hE5); push_lat(1'b0, 8'hF6);
        reg_write(3'd0, 32'h9F00_0000);
        reg_read(3'd0, s);
        chk(s[0] == 1'b0 && irq == 1'b0, "R8 done cleared by start", s, 32'h8000_0000);
        wait_idle();
        reg_read(3'd0, s);
        chk(s == 32'h0000_0001, "R8 done without irq enable", s, 32'h0000_0001);
        chk(irq == 1'b0, "R8 irq gated off", 32'(irq), 32'd0);

        // Partial mask 0x0A: B then E
        push_lat(1'b1, 8'h77);
        push_lat(1'b0, 8'hB2); push_lat(1'b0, 8'hE5);
        reg_write(3'd0, 32'h8A77_0000);
        wait_idle();
        chk(exp_lat.size() == 0, "R3 partial mask bytes consumed", 32'(exp_lat.size()), 32'd0);

        // Second cycle with wait and full page + spare
        snap = n_latch;
        push_lat(1'b1, 8'h30);
        push_read(2112, 32'h0001_0000, 32'h0008_0000);
        reg_write(3'd0, 32'h8030_B840);
        repeat (20) @(negedge clk);
        chk(n_latch == snap + 1, "R5 command sent before wait", 32'(n_latch - snap), 32'd1);
        reg_write(3'd0, 32'hC0EE_0000);  // R9 ignored while busy
        nf_rb_n = 1'b0;
        snap = n_stream;
        repeat (30) @(negedge clk);
        reg_read(3'd0, s);
        chk(s[31] == 1'b1, "R5 busy while device busy", s, 32'h8000_0000);
        chk(n_stream == snap, "R5 no stream during wait", 32'(n_stream - snap), 32'd0);
        nf_rb_n = 1'b1;
        wait_idle();
        reg_read(3'd0, s);
        chk(s == 32'h0000_0001, "R9 busy write left no trace", s, 32'h0000_0001);
        chk(exp_str.size() == 0, "R7 full page delivered", 32'(exp_str.size()), 32'd0);

        // Data flag with zero length: no read
        snap = n_stream;
        push_lat(1'b1, 8'h40);
        reg_write(3'd0, 32'h8040_2000);
        wait_idle();
        chk(n_stream == snap, "R6 zero length gives no stream", 32'(n_stream - snap), 32'd0);

        // Short read without wait
        push_lat(1'b1, 8'h50);
        push_read(5, 32'h0001_0000, 32'h0008_0000);
        reg_write(3'd0, 32'h8050_2005);
        wait_idle();
        chk(exp_str.size() == 0, "R6 short read delivered", 32'(exp_str.size()), 32'd0);
        chk(exp_lat.size() == 0, "R2 all bus cycles seen", 32'(exp_lat.size()), 32'd0);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule